// File: doc/BRIEF.md
# Toggle-handshake load/store sequencer

This unit is a rising-edge datapath controller that runs a fixed script of memory operations against a small word-addressed scratch array. A single start pulse makes it write the values 1, 2, 3 and 4 into words 0 to 3, read the four words back, and add them into a 32-bit result register. A done flag and an operation counter report progress.

The scratch array sits in the falling-edge half of the clock. The controller never lowers a request line. Instead it owns a request bit that it inverts to ask for one operation, and the array keeps its own copy of that bit. The array does work only while the two bits differ, and it makes its copy equal again when it finishes, so it switches itself off. Because the array acts half a cycle after a request, a store is finished one cycle after it is issued. A load's data is captured on the very next rising edge, which gives two rising edges from request to result. Back-to-back operations need no idle state between them.

Controller states and transitions: `ST_IDLE` goes to `ST_STORE` when start is seen, and issues the store to word 0. `ST_STORE` issues the next store every cycle. After the last store it issues the load of word 0 and goes to `ST_LOAD`. `ST_LOAD` adds the returned word to the result every cycle and issues the next load. After the last word has been added it goes to `ST_DONE`. `ST_DONE` holds the result. On start it clears the result and begins again through `ST_STORE`, exactly as from `ST_IDLE`.

Top module: `tgl_seq_top`

## Requirements
- R1: A synchronous reset on a rising edge sets result to 0, done to 0 and op_count to 0, and leaves the controller in `ST_IDLE`.
- R2: When start is sampled high in `ST_IDLE`, that edge is edge 1. On edges 1 to 4 the controller issues the stores of values 1 to 4 to words 0 to 3, one per edge. op_count reads k after edge k for k = 1 to 4.
- R3: The array is active exactly when its own enable copy differs from the controller's request bit. On an active falling edge it performs the operation and copies the request bit, so the two bits are equal at every rising edge after reset.
- R4: A load issued on edge k is added to result on edge k+1. The loads of words 0 to 3 are issued on edges 5 to 8, and op_count reads 5 to 8 after those edges. result reads 0 after edges 1 to 5, and reads 1, 3, 6 and 10 after edges 6, 7, 8 and 9.
- R5: done rises on edge 9 with result equal to 10 (the sum 1+2+3+4) and op_count equal to 8.
- R6: While the array is disabled, its data-out register and its stored words keep their values. Words written by one run therefore read back unchanged after any number of idle cycles.
- R7: start is ignored in `ST_STORE` and `ST_LOAD`. A start pulse during a run leaves the edge-by-edge values of R2 and R4 unchanged.
- R8: start in `ST_DONE` restarts the script. On that edge result returns to 0, done returns to 0 and op_count reads 1, and the run then follows R2, R4 and R5.
- R9: In `ST_DONE` without start, result, done and op_count hold their values.
- R10: A reset during a run gives the R1 state. A start after the reset runs the full script again from edge 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. The controller uses the rising edge and the array uses the falling edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts the script when sampled high in `ST_IDLE` or `ST_DONE` |
| result | output | 32 | Accumulated sum of the loaded words |
| done | output | 1 | High once the script has finished |
| op_count | output | 8 | Number of memory operations issued in the current run |

## Verification
The checker examines the handshake on every cycle. It confirms that the request bit and the array's copy agree at each rising edge, so the array has switched itself off after every operation. It also confirms that the data-out register keeps its value across any falling edge with no request, that op_count only holds, steps by one or restarts at one, and that done, once high, holds with a steady result until a new start. It further checks that done rises only with the full sum. Only the directed scenarios can show the exact edge on which each store and load lands. They also show the partial sums 1, 3, 6 and 10, that a start during a run has no effect, that a restart from `ST_DONE` behaves the same as a start from idle, and that a reset in the middle of a run recovers.

// File: rtl/tgl_seq_pkg.sv
package tgl_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STORE = 2'd1,
        ST_LOAD  = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_t;

endpackage

// File: rtl/tgl_mem.sv
// Self-disabling scratch array on the falling clock edge.
module tgl_mem #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_tgl,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              own_en
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];
    logic              active;

    assign active = (own_en != req_tgl);

    // Only this block drives own_en. It follows req_tgl after one service.
    always_ff @(negedge clk) begin
        if (rst) begin
            own_en <= 1'b0;
        end else if (active) begin
            own_en <= req_tgl;
        end
    end

    always_ff @(negedge clk) begin
        if (!rst && active && wr) begin
            words[addr] <= wdata;
        end
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (active && !wr) begin
            rdata <= words[addr];
        end
    end
endmodule

// File: rtl/tgl_ctrl.sv
// Rising-edge controller that runs the store / load / accumulate script.
module tgl_ctrl
    import tgl_seq_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4,
    parameter int N_WORDS = 4,
    parameter int CNT_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] rdata,
    output logic              req_tgl,
    output logic              wr,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] result,
    output logic              done,
    output logic [CNT_W-1:0]  op_count
);
    localparam int IDX_W = $clog2(N_WORDS + 1);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_WORDS);

    seq_state_t        state, state_nx;
    logic [IDX_W-1:0]  idx;
    logic              at_end;

    assign at_end = (idx == LAST);

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start)  state_nx = ST_STORE;
            ST_STORE: if (at_end) state_nx = ST_LOAD;
            ST_LOAD:  if (at_end) state_nx = ST_DONE;
            ST_DONE:  if (start)  state_nx = ST_STORE;
            default:              state_nx = ST_IDLE;
        endcase
    end

    // Outputs and datapath registers; req_tgl is only written here.
    always_ff @(posedge clk) begin
        if (rst) begin
            req_tgl  <= 1'b0;
            wr       <= 1'b0;
            addr     <= '0;
            wdata    <= '0;
            idx      <= '0;
            result   <= '0;
            done     <= 1'b0;
            op_count <= '0;
        end else begin
            unique case (state)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        req_tgl  <= ~req_tgl;
                        wr       <= 1'b1;
                        addr     <= '0;
                        wdata    <= DATA_W'(1);
                        idx      <= IDX_W'(1);
                        result   <= '0;
                        done     <= 1'b0;
                        op_count <= CNT_W'(1);
                    end
                end
                ST_STORE: begin
                    req_tgl  <= ~req_tgl;
                    op_count <= op_count + CNT_W'(1);
                    if (!at_end) begin
                        wr    <= 1'b1;
                        addr  <= ADDR_W'(idx);
                        wdata <= DATA_W'(idx) + DATA_W'(1);
                        idx   <= idx + IDX_W'(1);
                    end else begin
                        wr   <= 1'b0;
                        addr <= '0;
                        idx  <= IDX_W'(1);
                    end
                end
                ST_LOAD: begin
                    result <= result + rdata;
                    if (!at_end) begin
                        req_tgl  <= ~req_tgl;
                        wr       <= 1'b0;
                        addr     <= ADDR_W'(idx);
                        idx      <= idx + IDX_W'(1);
                        op_count <= op_count + CNT_W'(1);
                    end else begin
                        done <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tgl_seq_top.sv
module tgl_seq_top #(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4,
    parameter int N_WORDS = 4,
    parameter int CNT_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic [DATA_W-1:0] result,
    output logic              done,
    output logic [CNT_W-1:0]  op_count
);
    logic              uen;
    logic              men;
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] dout;

    tgl_ctrl #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_WORDS(N_WORDS), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .rdata(dout),
        .req_tgl(uen), .wr(wr), .addr(addr), .wdata(wdata),
        .result(result), .done(done), .op_count(op_count)
    );

    tgl_mem #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_mem (
        .clk(clk), .rst(rst), .req_tgl(uen), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(dout), .own_en(men)
    );
endmodule

// File: rtl/tgl_seq_chk.sv
module tgl_seq_chk #(
    parameter int DATA_W  = 32,
    parameter int N_WORDS = 4,
    parameter int CNT_W   = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              uen,
    input logic              men,
    input logic [DATA_W-1:0] dout,
    input logic [DATA_W-1:0] result,
    input logic              done,
    input logic [CNT_W-1:0]  op_count
);
    localparam logic [DATA_W-1:0] SUM = DATA_W'(N_WORDS * (N_WORDS + 1) / 2);

    AST_SELF_DISABLED: assert property (@(posedge clk) disable iff (rst)
        uen == men); // R3

    AST_DOUT_HOLD: assert property (@(negedge clk) disable iff (rst)
        (uen == men) |=> $stable(dout)); // R6

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (op_count == $past(op_count)) ||
                 (op_count == $past(op_count) + CNT_W'(1)) ||
                 (op_count == CNT_W'(1))); // R2

    AST_DONE_SUM: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (result == SUM)); // R5

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(result) && $stable(op_count))); // R9
endmodule

bind tgl_seq_top tgl_seq_chk #(
    .DATA_W(DATA_W), .N_WORDS(N_WORDS), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst(rst), .start(start), .uen(uen), .men(men),
    .dout(dout), .result(result), .done(done), .op_count(op_count)
);

// File: tb/sim_tgl_seq_top.sv
`timescale 1ns/1ps
module sim_tgl_seq_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] result;
    logic        done;
    logic [7:0]  op_count;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    tgl_seq_top u0 (
        .clk(clk), .rst(rst), .start(start),
        .result(result), .done(done), .op_count(op_count)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected values after edge k of a run, from R2, R4, R5.
    function automatic logic [31:0] exp_res(input int k);
        int s = 0;
        for (int j = 1; j <= k - 5; j++) s += j;
        return 32'(s);
    endfunction

    // Pulses start, then checks each of the nine edges of the run.
    task automatic run_script(input string tag, input bit poke);
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        for (int k = 1; k <= 9; k++) begin
            if (k > 1) begin
                @(posedge clk); #1;
                start = poke && (k == 3);
            end
            @(negedge clk);
            check({tag, " R2/R4 op_count"}, 32'(op_count), 32'(k < 8 ? k : 8));
            check({tag, " R4 result"}, result, exp_res(k));
            check({tag, " R5 done"}, 32'(done), 32'(k == 9));
        end
        start = 1'b0;
    endtask

    task automatic do_reset;
        @(posedge clk); #1 rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R1 result", result, 32'd0);
        check("R1 done", 32'(done), 32'd0);
        check("R1 op_count", 32'(op_count), 32'd0);
    endtask

    task automatic test_hold;
        repeat (20) @(posedge clk);
        @(negedge clk);
        check("R9 result", result, 32'd10);
        check("R9 done", 32'(done), 32'd1);
        check("R9 op_count", 32'(op_count), 32'd8);
    endtask

    task automatic test_restart;
        // R8: start in DONE clears the result on the start edge
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        @(negedge clk);
        check("R8 result cleared", result, 32'd0);
        check("R8 done cleared", 32'(done), 32'd0);
        check("R8 op_count", 32'(op_count), 32'd1);
        repeat (8) @(posedge clk);
        @(negedge clk);
        check("R8 final result", result, 32'd10);
        check("R8 final done", 32'(done), 32'd1);
    endtask

    task automatic test_mid_reset;
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        repeat (5) @(posedge clk);
        #1;
        check("R10 mid-run op_count", 32'(op_count), 32'd6);
        do_reset();
        check("R10 after reset result", result, 32'd0);
        run_script("R10 rerun", 1'b0);
    endtask

    initial begin
        do_reset();                       // R1
        run_script("R2 first", 1'b0);     // R2 R3 R4 R5
        test_hold();                      // R9 R6
        test_restart();                   // R8 R6
        run_script("R7 poke", 1'b0);      // from DONE, plain
        test_hold();
        run_script("R7 busy-start", 1'b1);// R7
        test_mid_reset();                 // R10
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 5000) begin
                checks++;
                errors++;
                $display("FAIL watchdog actual=%0d expected=<5000", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end
endmodule